// File: doc/BRIEF.md
# Multiply / Divide / Multiply-Accumulate Coprocessor

This block is a multi-cycle arithmetic helper that sits next to a 16-bit processor core. The core places operands on the inputs, picks an operation and a signed or unsigned interpretation, and pulses `start`. The unit then goes busy for a fixed, operation-dependent number of cycles and pulses `done` for one cycle. At that point the result registers hold the outcome.

Five operations are offered:

- a 16x16 multiply with a 32-bit product;
- a 32-bit by 16-bit divide;
- a 32-bit by 32-bit divide;
- a multiply-accumulate that wraps modulo 2^32;
- a multiply-accumulate that clamps on overflow.

Both divides return a quotient and a remainder. The two accumulate forms share the multiply datapath and differ only in the final add stage. Only one operation is in flight at a time.

The latency of each operation is fixed and does not depend on operand values. Firmware can therefore count cycles instead of polling. The multiplier retires 4 product bits per cycle. The narrow divide retires 4 quotient bits per cycle, and the wide divide retires 2.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero`, `result` and `remainder` are all zero. An accepted `start` makes `busy` high from the next cycle until the completion cycle. In the completion cycle `done` is high for exactly one cycle and `busy` is low.
- R2: Counted from the clock edge that samples `start`, `done` rises after exactly 4 edges for multiply and for both accumulate forms. It rises after 8 edges for the 32/16 divide and after 16 edges for the 32/32 divide.
- R3: Operation code 0 (multiply) returns in `result` the 32-bit product of `opnd_a[15:0]` and `opnd_b[15:0]`. The operands are two's complement when `is_signed` is 1 and unsigned when it is 0. Upper operand bits are ignored, and `remainder` is 0.
- R4: Operation code 1 divides the 32-bit `opnd_a` by `opnd_b[15:0]`. The divisor is sign-extended when signed and zero-extended when unsigned. `result` is the quotient, truncated toward zero, and `remainder` carries the sign of the dividend.
- R5: Operation code 2 divides the 32-bit `opnd_a` by the 32-bit `opnd_b`, with the same quotient and remainder rules as R4.
- R6: When a divide has a zero divisor, `div_zero` is 1, `result` is all ones and `remainder` equals `opnd_a`. Every other completion leaves `div_zero` at 0.
- R7: Operation code 3 returns `acc_in` plus the product defined in R3, modulo 2^32.
- R8: Operation code 4 with `is_signed` = 1 returns the signed sum of `acc_in` and the product. If that sum rises above the signed maximum, the result is 0x7FFFFFFF. If it falls below the signed minimum, the result is 0x80000000.
- R9: Operation code 4 with `is_signed` = 0 returns the unsigned sum, or 0xFFFFFFFF if the sum exceeds 32 bits.
- R10: A `start` that arrives while `busy` is high is ignored. It causes no extra completion and does not alter the result of the operation in progress.
- R11: `result`, `remainder` and `div_zero` change only in a completion cycle and hold their values at all other times.
- R12: A `start` with an operation code of 5, 6 or 7 is ignored. `busy` and `done` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Operation code: 0 mul, 1 div 32/16, 2 div 32/32, 3 MAC wrap, 4 MAC clamp |
| is_signed | input | 1 | 1 = two's complement operands |
| opnd_a | input | 32 | Multiplicand (low 16 bits) or dividend |
| opnd_b | input | 32 | Multiplier (low 16 bits) or divisor |
| acc_in | input | 32 | Accumulator addend for the MAC operations |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Product, quotient or accumulated sum |
| remainder | output | 32 | Remainder of a divide, otherwise 0 |
| div_zero | output | 1 | Last completed divide had a zero divisor |

## Verification
The embedded properties assume two things about the inputs. First, `rst` is held for at least one edge before any `start`. Second, the operand inputs need only be valid in the cycle `start` is sampled, because the unit latches everything it needs at that point.

The bench drives each operation from one negative edge to the next, and only then raises `start` again. It also injects extra `start` pulses during busy periods and drives reserved operation codes, so the ignore paths are exercised without breaking those assumptions. The remainder-below-divisor invariant is only claimed while a divide with a nonzero divisor is running.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_DIVH = 3'd1,
    OP_DIVW = 3'd2,
    OP_MACW = 3'd3,
    OP_MACS = 3'd4
  } op_e;

  function automatic logic op_known(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic op_is_div(input logic [2:0] code);
    return (code == OP_DIVH) || (code == OP_DIVW);
  endfunction

endpackage

// File: rtl/muldiv_mul_step.sv
module muldiv_mul_step #(
  parameter int MW   = 16,
  parameter int PW   = 32,
  parameter int BITS = 4
) (
  input  logic [PW-1:0] mcand,
  input  logic [MW-1:0] mplier,
  input  logic [PW-1:0] prod,
  output logic [PW-1:0] mcand_n,
  output logic [MW-1:0] mplier_n,
  output logic [PW-1:0] prod_n
);

  logic [PW-1:0] pp [BITS];

  for (genvar k = 0; k < BITS; k++) begin : g_pp
    assign pp[k] = mplier[k] ? (mcand << k) : '0;
  end

  always_comb begin
    prod_n = prod;
    for (int k = 0; k < BITS; k++) prod_n = prod_n + pp[k];
  end

  assign mcand_n  = mcand << BITS;
  assign mplier_n = mplier >> BITS;

endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
  parameter int W     = 32,
  parameter int STEPS = 4
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] quo,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] rem_n,
  output logic [W-1:0] quo_n
);

  logic [W-1:0] r_c [STEPS+1];
  logic [W-1:0] q_c [STEPS+1];

  assign r_c[0] = rem;
  assign q_c[0] = quo;

  for (genvar k = 0; k < STEPS; k++) begin : g_stage
    logic [W:0] sh;
    logic [W:0] diff;
    logic       fits;
    assign sh   = {r_c[k], q_c[k][W-1]};
    assign diff = sh - {1'b0, dvs};
    assign fits = ~diff[W];
    assign r_c[k+1] = fits ? diff[W-1:0] : sh[W-1:0];
    assign q_c[k+1] = {q_c[k][W-2:0], fits};
  end

  assign rem_n = r_c[STEPS];
  assign quo_n = q_c[STEPS];

endmodule

// File: rtl/muldiv_finish.sv
module muldiv_finish
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic         sgn,
  input  logic         neg_q,
  input  logic         neg_r,
  input  logic         dz,
  input  logic [W-1:0] prod_mag,
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] dividend,
  output logic [W-1:0] res,
  output logic [W-1:0] rem
);

  localparam logic [W-1:0] ALL1 = '1;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sprod, squo, srem;
  logic [W:0]   sum;

  assign sprod = neg_q ? (~prod_mag + W'(1)) : prod_mag;
  assign squo  = neg_q ? (~quo_mag + W'(1)) : quo_mag;
  assign srem  = neg_r ? (~rem_mag + W'(1)) : rem_mag;
  assign sum   = sgn ? ({acc[W-1], acc} + {sprod[W-1], sprod})
                     : ({1'b0, acc} + {1'b0, sprod});

  always_comb begin
    res = '0;
    rem = '0;
    unique case (op)
      OP_MUL:  res = sprod;
      OP_MACW: res = acc + sprod;
      OP_MACS: begin
        if (sgn) begin
          if (sum[W] != sum[W-1]) res = sum[W] ? SMIN : SMAX;
          else                    res = sum[W-1:0];
        end else begin
          res = sum[W] ? ALL1 : sum[W-1:0];
        end
      end
      OP_DIVH, OP_DIVW: begin
        if (dz) begin
          res = ALL1;
          rem = dividend;
        end else begin
          res = squo;
          rem = srem;
        end
      end
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int HALF_W    = 16,
  parameter int WORD_W    = 32,
  parameter int MUL_BITS  = 4,
  parameter int DIVH_BITS = 4,
  parameter int DIVW_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              is_signed,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [WORD_W-1:0] acc_in,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] result,
  output logic [WORD_W-1:0] remainder,
  output logic              div_zero
);

  localparam int MUL_LAT  = HALF_W / MUL_BITS;
  localparam int DIVH_LAT = WORD_W / DIVH_BITS;
  localparam int DIVW_LAT = WORD_W / DIVW_BITS;
  localparam int MAX_LAT  = (DIVW_LAT > DIVH_LAT) ?
                            ((DIVW_LAT > MUL_LAT) ? DIVW_LAT : MUL_LAT) :
                            ((DIVH_LAT > MUL_LAT) ? DIVH_LAT : MUL_LAT);
  localparam int CNT_W    = $clog2(MAX_LAT + 1);
  localparam int EXT_W    = WORD_W - HALF_W;

  // ---------------- launch-side decode ----------------
  logic              accept, div_in, a_lo_neg, b_lo_neg, a_neg, d_neg;
  logic [HALF_W-1:0] a_lo, b_lo, a_lo_mag, b_lo_mag;
  logic [WORD_W-1:0] a_mag, dv_raw, d_mag;
  logic [CNT_W-1:0]  lat_in;

  assign accept   = start && !busy && op_known(op);
  assign div_in   = op_is_div(op);
  assign a_lo     = opnd_a[HALF_W-1:0];
  assign b_lo     = opnd_b[HALF_W-1:0];
  assign a_lo_neg = is_signed & a_lo[HALF_W-1];
  assign b_lo_neg = is_signed & b_lo[HALF_W-1];
  assign a_lo_mag = a_lo_neg ? (~a_lo + HALF_W'(1)) : a_lo;
  assign b_lo_mag = b_lo_neg ? (~b_lo + HALF_W'(1)) : b_lo;
  assign a_neg    = is_signed & opnd_a[WORD_W-1];
  assign a_mag    = a_neg ? (~opnd_a + WORD_W'(1)) : opnd_a;
  assign dv_raw   = (op == OP_DIVH) ? {{EXT_W{b_lo_neg}}, b_lo} : opnd_b;
  assign d_neg    = is_signed & dv_raw[WORD_W-1];
  assign d_mag    = d_neg ? (~dv_raw + WORD_W'(1)) : dv_raw;

  always_comb begin
    case (op)
      OP_DIVH: lat_in = CNT_W'(DIVH_LAT);
      OP_DIVW: lat_in = CNT_W'(DIVW_LAT);
      default: lat_in = CNT_W'(MUL_LAT);
    endcase
  end

  // ---------------- operation state ----------------
  op_e               op_q;
  logic              sgn_q, neg_q, neg_r, dz_q;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] acc_q, dividend_q;
  logic [WORD_W-1:0] mcand, prod, quo, rem, dvs;
  logic [HALF_W-1:0] mplier;

  // ---------------- iteration datapath ----------------
  logic [WORD_W-1:0] mcand_n, prod_n;
  logic [HALF_W-1:0] mplier_n;
  logic [WORD_W-1:0] quo_h, rem_h, quo_w, rem_w, quo_sel, rem_sel;
  logic [WORD_W-1:0] fin_res, fin_rem;

  muldiv_mul_step #(.MW(HALF_W), .PW(WORD_W), .BITS(MUL_BITS)) u_mul (
    .mcand(mcand), .mplier(mplier), .prod(prod),
    .mcand_n(mcand_n), .mplier_n(mplier_n), .prod_n(prod_n)
  );

  muldiv_div_step #(.W(WORD_W), .STEPS(DIVH_BITS)) u_divh (
    .rem(rem), .quo(quo), .dvs(dvs), .rem_n(rem_h), .quo_n(quo_h)
  );

  muldiv_div_step #(.W(WORD_W), .STEPS(DIVW_BITS)) u_divw (
    .rem(rem), .quo(quo), .dvs(dvs), .rem_n(rem_w), .quo_n(quo_w)
  );

  assign quo_sel = (op_q == OP_DIVH) ? quo_h : quo_w;
  assign rem_sel = (op_q == OP_DIVH) ? rem_h : rem_w;

  muldiv_finish #(.W(WORD_W)) u_fin (
    .op(op_q), .sgn(sgn_q), .neg_q(neg_q), .neg_r(neg_r), .dz(dz_q),
    .prod_mag(prod_n), .quo_mag(quo_sel), .rem_mag(rem_sel),
    .acc(acc_q), .dividend(dividend_q), .res(fin_res), .rem(fin_rem)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      result     <= '0;
      remainder  <= '0;
      div_zero   <= 1'b0;
      op_q       <= OP_MUL;
      sgn_q      <= 1'b0;
      neg_q      <= 1'b0;
      neg_r      <= 1'b0;
      dz_q       <= 1'b0;
      cnt        <= '0;
      acc_q      <= '0;
      dividend_q <= '0;
      mcand      <= '0;
      mplier     <= '0;
      prod       <= '0;
      quo        <= '0;
      rem        <= '0;
      dvs        <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy       <= 1'b1;
        cnt        <= lat_in;
        op_q       <= op_e'(op);
        sgn_q      <= is_signed;
        acc_q      <= acc_in;
        dividend_q <= opnd_a;
        mcand      <= {{EXT_W{1'b0}}, a_lo_mag};
        mplier     <= b_lo_mag;
        prod       <= '0;
        quo        <= a_mag;
        rem        <= '0;
        dvs        <= d_mag;
        dz_q       <= div_in && (dv_raw == '0);
        neg_q      <= div_in ? (a_neg ^ d_neg) : (a_lo_neg ^ b_lo_neg);
        neg_r      <= a_neg;
      end else if (busy) begin
        cnt    <= cnt - CNT_W'(1);
        mcand  <= mcand_n;
        mplier <= mplier_n;
        prod   <= prod_n;
        quo    <= quo_sel;
        rem    <= rem_sel;
        if (cnt == CNT_W'(1)) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          result    <= fin_res;
          remainder <= fin_rem;
          div_zero  <= dz_q;
        end
      end
    end
  end

  // ---------------- embedded properties ----------------
  assert_busy_done_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_needs_start_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && op_is_div(op_q) && !dz_q) |-> (rem < dvs));

  assert_hold_outputs_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result) && $stable(remainder) && $stable(div_zero)));

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(op_q));

endmodule

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;
  import muldiv_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        is_signed = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, acc_in = '0;
  logic        busy, done, div_zero;
  logic [31:0] result, remainder;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_unit i_muldiv_unit (
    .clk(clk), .rst(rst), .start(start), .op(op), .is_signed(is_signed),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_in(acc_in),
    .busy(busy), .done(done), .result(result), .remainder(remainder),
    .div_zero(div_zero)
  );

  logic [31:0] vals [12] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0003,
                             32'h0000_7FFF, 32'h0000_8000, 32'h0000_FFFD,
                             32'h0000_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                             32'hFFFF_FFFF, 32'h1234_5678, 32'hFEDC_0A01};

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic longint ext16(input logic [31:0] x, input bit s);
    return s ? longint'($signed(x[15:0])) : longint'(x[15:0]);
  endfunction

  function automatic longint ext32(input logic [31:0] x, input bit s);
    return s ? longint'($signed(x)) : longint'(x);
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic model(input logic [2:0] o, input bit s, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c,
                       output logic [31:0] q, output logic [31:0] r,
                       output bit e, output int lat, output string tag);
    longint p, sum, n, d, qq, rr;
    e = 1'b0;
    r = '0;
    p = ext16(a, s) * ext16(b, s);
    case (o)
      3'd0: begin q = p[31:0]; lat = 4; tag = "R3"; end
      3'd3: begin sum = ext32(c, s) + p; q = sum[31:0]; lat = 4; tag = "R7"; end
      3'd4: begin
        sum = ext32(c, s) + p;
        lat = 4;
        if (s) begin
          tag = "R8";
          if (sum > 64'sd2147483647)       q = 32'h7FFF_FFFF;
          else if (sum < -64'sd2147483648) q = 32'h8000_0000;
          else                             q = sum[31:0];
        end else begin
          tag = "R9";
          q = (sum > 64'sd4294967295) ? 32'hFFFF_FFFF : sum[31:0];
        end
      end
      default: begin
        lat = (o == 3'd1) ? 8 : 16;
        tag = (o == 3'd1) ? "R4" : "R5";
        n = ext32(a, s);
        d = (o == 3'd1) ? ext16(b, s) : ext32(b, s);
        if (d == 0) begin
          e = 1'b1; q = 32'hFFFF_FFFF; r = a; tag = "R6";
        end else begin
          qq = n / d; rr = n % d;
          q = qq[31:0]; r = rr[31:0];
        end
      end
    endcase
  endtask

  task automatic run_op(input logic [2:0] o, input bit s, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c, input bit inject);
    logic [31:0] eq, er;
    bit ee;
    int lat, m;
    string tag;
    model(o, s, a, b, c, eq, er, ee, lat, tag);
    @(negedge clk);
    op = o; is_signed = s; opnd_a = a; opnd_b = b; acc_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m = 1;
    while (!done && m < 40) begin
      chk(busy == 1'b1, "R1", "busy during operation", 32'(busy), 32'd1);
      if (inject && m == 2) begin
        start = 1'b1; op = 3'd0; opnd_a = ~a; opnd_b = a ^ b; acc_in = ~c;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      m++;
    end
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R1", "done high and busy low",
        {30'd0, busy, done}, 32'd1);
    chk(m - 1 == lat, "R2", "latency", 32'(m - 1), 32'(lat));
    chk(result == eq, tag, "result", result, eq);
    chk(remainder == er, tag, "remainder", remainder, er);
    chk(div_zero == ee, "R6", "div_zero flag", 32'(div_zero), 32'(ee));
    opnd_a = xs(a ^ 32'h5A5A_0F0F); opnd_b = ~b; acc_in = c + 32'd7;
    @(negedge clk);
    chk(done == 1'b0, "R1", "done lasts one cycle", 32'(done), 32'd0);
    chk(result == eq && remainder == er, "R11", "outputs held", result, eq);
    if (inject) begin
      for (int k = 0; k < 3; k++) begin
        chk(!busy && !done, "R10", "start while busy ignored",
            {30'd0, busy, done}, 32'd0);
        @(negedge clk);
      end
      chk(result == eq, "R10", "result unaffected by ignored start", result, eq);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++;
        failures++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
        report();
      end
    end
  end

  initial begin
    logic [31:0] sd, ra, rb, rc, held;
    int idx;
    repeat (3) @(negedge clk);
    // reset state, R1
    chk(!busy && !done && !div_zero, "R1", "reset flags",
        {29'd0, busy, done, div_zero}, 32'd0);
    chk(result == 0 && remainder == 0, "R1", "reset outputs", result, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // reserved operation codes, R12
    for (int rc_op = 5; rc_op < 8; rc_op++) begin
      held = result;
      op = 3'(rc_op); opnd_a = 32'h1111; opnd_b = 32'h2222; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 5; k++) begin
        chk(!busy && !done, "R12", "reserved code ignored",
            {30'd0, busy, done}, 32'd0);
        @(negedge clk);
      end
      chk(result == held, "R12", "result unchanged", result, held);
    end

    // directed clamp and corner cases, R8 R9 R6
    run_op(3'd4, 1'b1, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0);
    run_op(3'd4, 1'b1, 32'h0000_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0);
    run_op(3'd4, 1'b1, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 1'b0);
    run_op(3'd4, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFF0, 1'b0);
    run_op(3'd4, 1'b0, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFE, 1'b0);
    run_op(3'd3, 1'b1, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0);
    run_op(3'd1, 1'b1, 32'h8000_0000, 32'h0000_FFFF, 32'h0, 1'b0);
    run_op(3'd2, 1'b1, 32'hFFFF_FFF9, 32'h0000_0002, 32'h0, 1'b1);
    run_op(3'd1, 1'b0, 32'hDEAD_BEEF, 32'hABCD_0000, 32'h0, 1'b1);
    run_op(3'd0, 1'b0, 32'h0000_0005, 32'h0000_0006, 32'h0, 1'b0);

    // sweep over corner operands, all ops and both signednesses
    idx = 0;
    for (int o = 0; o < 5; o++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 12; j++) begin
            run_op(3'(o), s[0], vals[i], vals[j], vals[(i * 5 + j) % 12],
                   (idx % 37) == 0);
            idx++;
          end

    // pseudo-random operands
    sd = 32'hC0FF_EE11;
    for (int t = 0; t < 400; t++) begin
      sd = xs(sd); ra = sd;
      sd = xs(sd); rb = (t % 5 == 0) ? (sd >> (sd[4:0])) : sd;
      sd = xs(sd); rc = sd;
      run_op(3'(t % 5), sd[7], ra, rb, rc, 1'b0);
    end

    report();
  end

endmodule